// File: doc/BRIEF.md
# Universal Bidirectional Registered Bus Transceiver

This block links two 18-bit ports, A and B. Each direction has its own storage element, and that element works in one of two ways. While its latch-enable is high, the element is transparent: the destination port follows the source port with no clock involved. While its latch-enable is low, the element holds its value. It then loads a new source value only on the falling edge of its own clock. This lets one block act as a plain buffer, a latch or a pipeline register, and each direction can be set up separately.

The destination side of each direction is a tri-state driver. It is modelled as a data vector plus a per-bit drive-enable vector. The A-to-B enable is active-high and the B-to-A enable is active-low. The enables act only on the drivers, so the storage elements keep working while the outputs float. Both directions may drive at the same time. A synchronous active-high reset clears both storage elements: the latch half clears while reset is high, and the register half clears on a falling edge of its clock.

Top module: `ubt_xcvr`

## Requirements
- R1: Each direction carries all 18 bits, from bit 0 to bit 17. An all-ones source value reaches the destination unchanged.
- R2: While a direction's latch-enable is 1, its destination data equals its source data in the same cycle, with no clock edge needed.
- R3: While the latch-enable is 0 and the clock does not change, the destination keeps the last stored value, however the source changes. When the latch-enable falls, that value is the source value present just before it fell.
- R4: While the latch-enable is 0, a 1-to-0 edge of the direction's clock loads the source value. A 0-to-1 edge loads nothing.
- R5: When the A-to-B enable `oe_ab` is 1, every bit of `b_oe` is 1 and `b_out` shows the stored A-to-B value. When `oe_ab` is 0, every bit of `b_oe` is 0, so the B outputs are high-impedance.
- R6: When the B-to-A enable `oe_ba_n` is 0, every bit of `a_oe` is 1 and `a_out` shows the stored B-to-A value. When `oe_ba_n` is 1, every bit of `a_oe` is 0.
- R7: A value captured while a direction's outputs are disabled appears as soon as the outputs are enabled again.
- R8: A falling clock edge while the latch-enable is 1 has no effect of its own. The destination still follows the source.
- R9: While `rst` is 1, and after a falling edge of the direction clock, the stored value is 0. With the latch-enable at 0 after reset, the destination reads 0.
- R10: The two directions are independent. Clock and enable activity in one direction does not change the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset of both storage elements |
| a_in | input | 18 | Value received from port A |
| b_in | input | 18 | Value received from port B |
| le_ab | input | 1 | A-to-B latch-enable, 1 = transparent |
| clk_ab | input | 1 | A-to-B clock, loads on its falling edge |
| oe_ab | input | 1 | A-to-B output enable, active-high |
| le_ba | input | 1 | B-to-A latch-enable, 1 = transparent |
| clk_ba | input | 1 | B-to-A clock, loads on its falling edge |
| oe_ba_n | input | 1 | B-to-A output enable, active-low |
| b_out | output | 18 | Data driven onto port B |
| b_oe | output | 18 | Per-bit drive-enable for port B |
| a_out | output | 18 | Data driven onto port A |
| a_oe | output | 18 | Per-bit drive-enable for port A |

## Verification
The assertions sample on the falling edge of each direction clock. They assume that the latch-enable and the source data are settled at that edge, and that the latch-enable does not pulse high between two falling edges while a captured value is being tracked. The stimulus changes data, enables and clocks only at separate, spaced instants after the bench clock edge, one step at a time. It therefore never places a control change and a clock edge in the same instant. The bench resolves each disabled output bit to Z and compares the result with a value it works out from the mode sequence it has applied.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    parameter int DATA_W = 18;

    // Which half of a storage element currently holds the newest value
    typedef enum logic {
        SEL_LATCH = 1'b0,
        SEL_FLOP  = 1'b1
    } src_sel_e;

    // Output-enable pin polarity of a direction
    typedef enum logic {
        OE_ACTIVE_HIGH = 1'b0,
        OE_ACTIVE_LOW  = 1'b1
    } oe_pol_e;

    // Converts an enable pin level into "drivers on"
    function automatic logic drive_on(oe_pol_e pol, logic pin);
        return (pol == OE_ACTIVE_HIGH) ? pin : ~pin;
    endfunction

endpackage

// File: rtl/ubt_store.sv
module ubt_store
    import ubt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         rst,
    input  logic         le,
    input  logic         clk,
    input  logic [W-1:0] src,
    output logic [W-1:0] q
);

    logic [W-1:0] lat_q;
    logic [W-1:0] flop_q;
    src_sel_e     sel_q;

    // Level-sensitive half: tracks the source while transparent
    always_latch begin
        if (rst)
            lat_q = '0;
        else if (le)
            lat_q = src;
    end

    // Edge-triggered half: loads on the falling clock edge while not transparent
    always_ff @(negedge clk) begin
        if (rst)
            flop_q <= '0;
        else if (!le)
            flop_q <= src;
    end

    // Newest-value tracker: a high latch-enable hands ownership to the latch,
    // a falling edge with the latch-enable low hands it to the register
    always_ff @(negedge clk or posedge le) begin
        if (le)
            sel_q <= SEL_LATCH;
        else
            sel_q <= SEL_FLOP;
    end

    assign q = (sel_q == SEL_FLOP) ? flop_q : lat_q;

    // R2 / R8: transparent element shows the source even at a falling edge
    a_r2_transparent: assert property (@(negedge clk) disable iff (rst)
        le |-> (q == src));

    // R4: a falling edge with latch-enable low loads the source into the register
    a_r4_fall_capture: assert property (@(negedge clk) disable iff (rst)
        !le |=> (flop_q == $past(src)));

    // R9: reset seen at a falling edge leaves the register cleared
    a_r9_reset_clear: assert property (@(negedge clk)
        rst |=> (flop_q == '0));

endmodule

// File: rtl/ubt_drive.sv
module ubt_drive
    import ubt_pkg::*;
#(
    parameter int      W   = DATA_W,
    parameter oe_pol_e POL = OE_ACTIVE_HIGH
) (
    input  logic         oe_pin,
    input  logic [W-1:0] d,
    output logic [W-1:0] dout,
    output logic [W-1:0] den
);

    logic on;

    generate
        if (POL == OE_ACTIVE_HIGH) begin : g_pol_high
            assign on = drive_on(OE_ACTIVE_HIGH, oe_pin);
        end else begin : g_pol_low
            assign on = drive_on(OE_ACTIVE_LOW, oe_pin);
        end
    endgenerate

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign den[i]  = on;
            assign dout[i] = d[i];
        end
    endgenerate

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         le_ab,
    input  logic         clk_ab,
    input  logic         oe_ab,
    input  logic         le_ba,
    input  logic         clk_ba,
    input  logic         oe_ba_n,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe
);

    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;

    ubt_store #(.W(W)) u_store_ab (
        .rst (rst),
        .le  (le_ab),
        .clk (clk_ab),
        .src (a_in),
        .q   (ab_q)
    );

    ubt_store #(.W(W)) u_store_ba (
        .rst (rst),
        .le  (le_ba),
        .clk (clk_ba),
        .src (b_in),
        .q   (ba_q)
    );

    ubt_drive #(.W(W), .POL(OE_ACTIVE_HIGH)) u_drive_b (
        .oe_pin (oe_ab),
        .d      (ab_q),
        .dout   (b_out),
        .den    (b_oe)
    );

    ubt_drive #(.W(W), .POL(OE_ACTIVE_LOW)) u_drive_a (
        .oe_pin (oe_ba_n),
        .d      (ba_q),
        .dout   (a_out),
        .den    (a_oe)
    );

    // R5: active-high enable drives B with the stored A-to-B value
    a_r5_b_driven: assert property (@(negedge clk_ab) disable iff (rst)
        oe_ab |-> (&b_oe && b_out == ab_q));

    // R5: low enable floats every B bit
    a_r5_b_float: assert property (@(negedge clk_ab) disable iff (rst)
        !oe_ab |-> (b_oe == '0));

    // R6: active-low enable drives A with the stored B-to-A value
    a_r6_a_driven: assert property (@(negedge clk_ba) disable iff (rst)
        !oe_ba_n |-> (&a_oe && a_out == ba_q));

    // R6: high enable floats every A bit
    a_r6_a_float: assert property (@(negedge clk_ba) disable iff (rst)
        oe_ba_n |-> (a_oe == '0));

endmodule

// File: tb/test_ubt_xcvr.sv
module test_ubt_xcvr;

    localparam int W = 18;
    localparam time HALF = 10ns;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         le_ab, clk_ab, oe_ab;
    logic         le_ba, clk_ba, oe_ba_n;
    logic [W-1:0] b_out, b_oe, a_out, a_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(HALF) clk = ~clk;

    ubt_xcvr #(.W(W)) i_ubt_xcvr (
        .rst(rst), .a_in(a_in), .b_in(b_in),
        .le_ab(le_ab), .clk_ab(clk_ab), .oe_ab(oe_ab),
        .le_ba(le_ba), .clk_ba(clk_ba), .oe_ba_n(oe_ba_n),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
    );

    function automatic logic [W-1:0] pat(int i);
        logic [31:0] v;
        v = (i * 32'h0002D3B5 + 32'h000000A5) ^ (i << 9);
        return v[W-1:0];
    endfunction

    function automatic logic [W-1:0] resolve(logic [W-1:0] v, logic [W-1:0] en);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = en[k] ? v[k] : 1'bz;
        return r;
    endfunction

    function automatic logic [W-1:0] expect_bus(logic [W-1:0] v, logic en);
        return en ? v : {W{1'bz}};
    endfunction

    task automatic chk_b(string tag, logic [W-1:0] v, logic en);
        logic [W-1:0] act, exp;
        act = resolve(b_out, b_oe);
        exp = expect_bus(v, en);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s port B: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_a(string tag, logic [W-1:0] v, logic en);
        logic [W-1:0] act, exp;
        act = resolve(a_out, a_oe);
        exp = expect_bus(v, en);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s port A: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic fall_ab(); clk_ab = 1'b0; #1; endtask
    task automatic rise_ab(); clk_ab = 1'b1; #1; endtask
    task automatic fall_ba(); clk_ba = 1'b0; #1; endtask
    task automatic rise_ba(); clk_ba = 1'b1; #1; endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; le_ab = 1'b0; le_ba = 1'b0;
        clk_ab = 1'b1; clk_ba = 1'b1;
        oe_ab = 1'b1; oe_ba_n = 1'b0;
        a_in = pat(3); b_in = pat(4);
        step();
        fall_ab(); fall_ba(); step();
        rise_ab(); rise_ba(); step();
        rst = 1'b0; #1;
        chk_b("R9 reset", '0, 1'b1);
        chk_a("R9 reset", '0, 1'b1);
        a_in = pat(5); b_in = pat(6); #1;
        chk_b("R9 held after reset", '0, 1'b1);
        chk_a("R9 held after reset", '0, 1'b1);

        // R2: transparent sweeps in both directions
        step();
        le_ab = 1'b1; le_ba = 1'b1;
        for (int i = 0; i < 24; i++) begin
            a_in = pat(i); b_in = pat(i + 40); #1;
            chk_b("R2 transparent", pat(i), 1'b1);
            chk_a("R2 transparent", pat(i + 40), 1'b1);
        end

        // R1: full width, both edge bits
        a_in = {W{1'b1}}; b_in = {1'b1, {(W-2){1'b0}}, 1'b1}; #1;
        chk_b("R1 width", {W{1'b1}}, 1'b1);
        chk_a("R1 width", {1'b1, {(W-2){1'b0}}, 1'b1}, 1'b1);

        // R3: hold after latch-enable falls, clock steady
        step();
        a_in = pat(50); #1;
        le_ab = 1'b0; #1;
        for (int j = 0; j < 8; j++) begin
            a_in = pat(60 + j); #1;
            chk_b("R3 hold", pat(50), 1'b1);
        end
        b_in = pat(51); #1;
        le_ba = 1'b0; #1;
        b_in = pat(52); #1;
        chk_a("R3 hold", pat(51), 1'b1);

        // R4: falling edge loads, rising edge does not
        for (int i = 0; i < 16; i++) begin
            step();
            a_in = pat(100 + i); #1;
            fall_ab();
            chk_b("R4 fall capture", pat(100 + i), 1'b1);
            a_in = pat(200 + i); #1;
            rise_ab();
            chk_b("R4 no rise capture", pat(100 + i), 1'b1);
        end
        for (int i = 0; i < 6; i++) begin
            step();
            b_in = pat(150 + i); #1;
            fall_ba();
            chk_a("R4 fall capture", pat(150 + i), 1'b1);
            b_in = pat(250 + i); #1;
            rise_ba();
            chk_a("R4 no rise capture", pat(150 + i), 1'b1);
        end

        // R8: falling edge while transparent
        step();
        le_ab = 1'b1; a_in = pat(300); #1;
        fall_ab();
        chk_b("R8 edge while transparent", pat(300), 1'b1);
        a_in = pat(301); #1;
        chk_b("R8 still transparent", pat(301), 1'b1);
        le_ab = 1'b0; #1;
        a_in = pat(302); #1;
        chk_b("R8 keeps last source", pat(301), 1'b1);
        rise_ab();
        chk_b("R8 rise after", pat(301), 1'b1);

        // R5 and R7: A-to-B disabled, storage keeps working
        step();
        oe_ab = 1'b0; #1;
        chk_b("R5 float", '0, 1'b0);
        a_in = pat(400); #1;
        fall_ab(); rise_ab();
        chk_b("R5 float after capture", '0, 1'b0);
        oe_ab = 1'b1; #1;
        chk_b("R7 capture while floating", pat(400), 1'b1);

        // R6 and R7: B-to-A polarity
        step();
        oe_ba_n = 1'b1; #1;
        chk_a("R6 float", '0, 1'b0);
        b_in = pat(410); #1;
        fall_ba(); rise_ba();
        oe_ba_n = 1'b0; #1;
        chk_a("R7 capture while floating", pat(410), 1'b1);
        oe_ab = 1'b0; #1;
        chk_a("R10 other enable ignored", pat(410), 1'b1);
        oe_ab = 1'b1; #1;

        // R10: independent directions driven at once
        step();
        le_ab = 1'b1; a_in = pat(500); b_in = pat(501); #1;
        fall_ab();
        chk_b("R10 A-to-B active", pat(500), 1'b1);
        chk_a("R10 B-to-A untouched", pat(410), 1'b1);
        rise_ab();
        le_ab = 1'b0; #1;
        fall_ba();
        chk_a("R10 B-to-A capture", pat(501), 1'b1);
        chk_b("R10 A-to-B untouched", pat(500), 1'b1);
        rise_ba();

        step();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule